// File: doc/BRIEF.md
# Dead-Band Generator with Shadowed Delay Registers

This block turns one PWM level into two complementary gate-drive signals with a programmable gap between them. Output A follows the input, and output B follows the inverted input. Each output's rising edge is held back by its own count of clock cycles, so the two switches of a half bridge are never on together. A falling edge on the source of an output drives that output low straight away.

Each delay count has a pending copy and an active copy. A write always goes to the pending copy. A control field chooses when the pending copy becomes active:
- In immediate mode it becomes active on the next clock.
- In local mode it becomes active at the next PWM counter-zero strobe.
- In global mode it becomes active at the first counter-zero strobe after a master update request.

If a pending value is written again before it commits, the new value replaces it and the older value is never used. Software reaches the block through a small write port that carries the two delay counts, the update mode and the enable.

Top module: `dbg_deadband`

## Requirements
- R1: While reset is asserted, both outputs are low. After reset, both delays are zero, the mode is immediate (code 0) and the dead-band function is disabled.
- R2: When the function is enabled with rise delay D, output A goes high D+1 clocks after the first clock edge that samples the input high. This is D cycles later than a zero delay would give.
- R3: If an input high pulse lasts D clock samples or fewer, output A stays low for the whole pulse.
- R4: A low input sample drives output A low on the next clock. It also restarts the count, so a later high needs the full delay again.
- R5: Output B behaves as output A does, but it follows the inverted input and uses the fall delay (address 1). Output A uses the rise delay (address 0).
- R6: When the function is disabled (control bit 2 = 0), output A is the input delayed by one register stage and output B is its inverse. The programmed delays have no effect.
- R7: In immediate mode (control bits 1:0 = 0, or the unused code 3), a written delay is active from the next clock.
- R8: In local mode (control bits 1:0 = 1), a written delay becomes active at the next clock edge that samples cnt_zero high. A write sampled in the same cycle as cnt_zero commits at that edge.
- R9: In global mode (control bits 1:0 = 2), a written delay commits only at a cnt_zero edge while the request flag is set. The request flag is set by a gsync_req pulse sampled in an earlier cycle. It clears at that cnt_zero edge unless gsync_req is high again.
- R10: If a delay is rewritten while a value is still pending, only the latest value ever becomes active.
- R11: With the function enabled and a delay of zero, the output equals the input (or its inverse for B) one register stage later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Write target: 0 = rise delay, 1 = fall delay, 2 = control |
| wr_data | input | 12 | Write data. For control writes, bits 1:0 are the mode and bit 2 is the enable |
| cnt_zero | input | 1 | PWM counter-zero strobe |
| gsync_req | input | 1 | Master update request strobe |
| pwm_in | input | 1 | PWM source level |
| gate_a | output | 1 | Output A: input with its rising edge delayed |
| gate_b | output | 1 | Output B: inverted input with its rising edge delayed |

## Verification
The bench checks the output latency against the delay. A design with an off-by-one count would show the rising edge one cycle early or late on every pulse. It drives pulses shorter than the delay and drops the input in the middle of a countdown. A design that failed to restart its count would show a late glitch high, or a next pulse that rises too soon. The update ordering is tested in three ways: a write in the same cycle as counter zero, a double write before the commit, and a counter zero both without and with a master request. A wrong design would adopt the stale value, commit too early, or keep the request flag set so that it commits twice.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    UPD_NOW    = 2'd0,
    UPD_LOCAL  = 2'd1,
    UPD_GLOBAL = 2'd2,
    UPD_SPARE  = 2'd3
  } upd_mode_e;

  localparam int unsigned CTRL_EN_BIT = 2;
endpackage

// File: rtl/dbg_shadow.sv
module dbg_shadow
  import dbg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  upd_mode_e    mode,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         zero_evt,
  input  logic         gflag,
  output logic [W-1:0] active
);
  logic [W-1:0] pend_q, active_q;
  logic         pflag_q;

  // events brought out for assertions
  logic         has_pend;
  logic [W-1:0] next_pend;
  logic         commit_now;

  function automatic logic sync_commit(input upd_mode_e m, input logic hp,
                                       input logic z, input logic g);
    case (m)
      UPD_LOCAL:  sync_commit = hp & z;
      UPD_GLOBAL: sync_commit = hp & z & g;
      default:    sync_commit = 1'b0;
    endcase
  endfunction

  assign has_pend  = wr | pflag_q;
  assign next_pend = wr ? wdata : pend_q;
  assign commit_now = ((mode == UPD_NOW) || (mode == UPD_SPARE)) ? wr
                    : sync_commit(mode, has_pend, zero_evt, gflag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= '0;
      pflag_q  <= 1'b0;
    end else begin
      pend_q <= next_pend;
      if (commit_now) begin
        active_q <= next_pend;
        pflag_q  <= 1'b0;
      end else if ((mode == UPD_NOW) || (mode == UPD_SPARE)) begin
        pflag_q <= 1'b0;
      end else begin
        pflag_q <= has_pend;
      end
    end
  end

  assign active = active_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_now |=> $stable(active_q));
  p_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_NOW && wr) |=> active_q == $past(wdata));
  p_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_LOCAL && !zero_evt) |=> $stable(active_q));
  p_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == UPD_GLOBAL && !(zero_evt && gflag)) |=> $stable(active_q));
endmodule

// File: rtl/dbg_edge_delay.sv
module dbg_edge_delay #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         lvl_in,
  input  logic [W-1:0] dly,
  output logic         gate
);
  localparam logic [W-1:0] RUN_MAX = {W{1'b1}};

  logic [W-1:0] run_q;
  logic         gate_q;
  logic         wait_done;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    sat_inc = (v == RUN_MAX) ? v : v + 1'b1;
  endfunction

  assign wait_done = (run_q >= dly);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      gate_q <= 1'b0;
    end else if (!lvl_in) begin
      run_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      run_q  <= sat_inc(run_q);
      gate_q <= en ? wait_done : 1'b1;
    end
  end

  assign gate = gate_q;

  p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_in |=> !gate_q);
  p_src_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> $past(lvl_in));
  p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dly == '0) |=> gate_q == $past(lvl_in));
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> gate_q == $past(lvl_in));
endmodule

// File: rtl/dbg_deadband.sv
module dbg_deadband
  import dbg_pkg::*;
#(
  parameter int unsigned DLY_W  = 12,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DLY_W-1:0]  wr_data,
  input  logic              cnt_zero,
  input  logic              gsync_req,
  input  logic              pwm_in,
  output logic              gate_a,
  output logic              gate_b
);
  localparam int unsigned NCH = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2);

  upd_mode_e mode_q;
  logic      en_q;
  logic      gflag_q;
  logic      ctrl_wr;
  logic [NCH-1:0] ch_gate;

  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= UPD_NOW;
      en_q   <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= upd_mode_e'(wr_data[1:0]);
      en_q   <= wr_data[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  gflag_q <= 1'b0;
    else if (gsync_req)          gflag_q <= 1'b1;
    else if (cnt_zero && gflag_q) gflag_q <= 1'b0;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic             ch_wr;
      logic [DLY_W-1:0] ch_dly;
      logic             ch_lvl;

      assign ch_wr  = wr_en && (wr_addr == ADDR_W'(i));
      assign ch_lvl = (i == 0) ? pwm_in : ~pwm_in;

      dbg_shadow #(.W(DLY_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .wr       (ch_wr),
        .wdata    (wr_data),
        .zero_evt (cnt_zero),
        .gflag    (gflag_q),
        .active   (ch_dly)
      );

      dbg_edge_delay #(.W(DLY_W)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q),
        .lvl_in (ch_lvl),
        .dly    (ch_dly),
        .gate   (ch_gate[i])
      );
    end
  endgenerate

  assign gate_a = ch_gate[0];
  assign gate_b = ch_gate[1];

  p_gflag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && gflag_q && !gsync_req) |=> !gflag_q);
  p_gflag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gsync_req |=> gflag_q);
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> !(gate_a && gate_b));
endmodule

// File: tb/dbg_deadband_test.sv
module dbg_deadband_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [11:0] wr_data = 12'd0;
  logic cnt_zero = 1'b0;
  logic gsync_req = 1'b0;
  logic pwm_in = 1'b0;
  logic gate_a, gate_b;

  always #5 clk = ~clk;

  dbg_deadband uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_zero(cnt_zero), .gsync_req(gsync_req),
    .pwm_in(pwm_in), .gate_a(gate_a), .gate_b(gate_b)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int act[2], pend[2], run[2];
  bit pf[2];
  bit m_out[2];
  int m_mode = 0;
  bit m_en = 0, m_gp = 0;

  task automatic check(string req, bit act_v, bit exp_v, string what);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      act[c] = 0; pend[c] = 0; run[c] = 0; pf[c] = 0; m_out[c] = 0;
    end
    m_mode = 0; m_en = 0; m_gp = 0;
  endtask

  task automatic model_edge();
    bit lvl, w, hp, commit;
    int np;
    for (int c = 0; c < 2; c++) begin
      lvl = (c == 0) ? pwm_in : !pwm_in;
      if (!lvl) begin
        m_out[c] = 0; run[c] = 0;
      end else begin
        m_out[c] = m_en ? (run[c] >= act[c]) : 1'b1;
        if (run[c] < 4095) run[c]++;
      end
    end
    for (int c = 0; c < 2; c++) begin
      w = wr_en && (wr_addr == c);
      np = w ? int'(wr_data) : pend[c];
      hp = w || pf[c];
      if (m_mode == 1)      commit = hp && cnt_zero;
      else if (m_mode == 2) commit = hp && cnt_zero && m_gp;
      else                  commit = w;
      pend[c] = np;
      if (commit) begin act[c] = np; pf[c] = 0; end
      else pf[c] = (m_mode == 1 || m_mode == 2) ? hp : 1'b0;
    end
    if (gsync_req) m_gp = 1;
    else if (cnt_zero && m_gp) m_gp = 0;
    if (wr_en && wr_addr == 2) begin
      m_mode = int'(wr_data[1:0]);
      m_en = wr_data[2];
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_req, gate_a, m_out[0], "gate_a");
    check(cur_req, gate_b, m_out[1], "gate_b");
    wr_en = 0; cnt_zero = 0; gsync_req = 0;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1; wr_addr = a; wr_data = 12'(d);
    step();
  endtask

  task automatic pulse(input int hi, input int lo);
    pwm_in = 1;
    repeat (hi) step();
    pwm_in = 0;
    repeat (lo) step();
  endtask

  initial begin
    int lat;
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", gate_a, 1'b0, "gate_a in reset");
    check("R1", gate_b, 1'b0, "gate_b in reset");
    rst_n = 1;
    repeat (3) step();

    cur_req = "R6";
    wr(2'd0, 9); wr(2'd1, 9);
    pulse(4, 4); pulse(1, 2); pulse(3, 1);

    cur_req = "R7";
    wr(2'd2, 4); wr(2'd0, 5); wr(2'd1, 3);
    pwm_in = 0; repeat (8) step();

    cur_req = "R2";
    pwm_in = 1; lat = 0;
    for (int k = 1; k <= 20; k++) begin
      step();
      if (gate_a && lat == 0) lat = k;
    end
    checks++;
    if (lat != 6) begin
      errors++;
      $display("FAIL R2 rise latency: actual=%0d expected=%0d", lat, 6);
    end
    pwm_in = 0; repeat (6) step();
    pulse(10, 10); pulse(7, 5);

    cur_req = "R5";
    pulse(6, 2); pulse(6, 3); pulse(6, 4); pulse(6, 8);

    cur_req = "R3";
    wr(2'd0, 8);
    pulse(5, 4); pulse(8, 4); pulse(9, 4);

    cur_req = "R4";
    pulse(4, 1); pulse(6, 1); pulse(12, 3);

    cur_req = "R11";
    wr(2'd0, 0); wr(2'd1, 0);
    pulse(1, 1); pulse(3, 2); pulse(1, 3);

    cur_req = "R8";
    wr(2'd2, 5);
    wr(2'd0, 4);
    pulse(7, 3);
    cnt_zero = 1; step();
    pulse(7, 3);
    wr_en = 1; wr_addr = 2'd1; wr_data = 12'd2; cnt_zero = 1; step();
    pulse(3, 6);

    cur_req = "R10";
    wr(2'd0, 7); wr(2'd0, 2);
    pulse(8, 3);
    cnt_zero = 1; step();
    pulse(8, 3);

    cur_req = "R9";
    wr(2'd2, 6);
    wr(2'd0, 6);
    cnt_zero = 1; step();
    pulse(8, 3);
    gsync_req = 1; cnt_zero = 1; step();
    pulse(8, 3);
    gsync_req = 1; step();
    pulse(8, 3);
    cnt_zero = 1; step();
    pulse(8, 3);
    wr(2'd0, 1);
    cnt_zero = 1; step();
    pulse(8, 3);
    gsync_req = 1; step();
    cnt_zero = 1; step();
    pulse(8, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule